// File: doc/BRIEF.md
# Flow-Through Burst SRAM Controller

This block is the synchronous control side of a flow-through burst static memory, with a behavioural storage array behind it. On every rising clock edge it looks at two address strobes, one owned by a processor and one by a memory controller, and at three chip enables. It loads a word address and runs a 2-bit burst counter that supplies the two low address bits. It also works out which 9-bit byte lanes a write touches and drives read data back out. Reads are flow-through: the word at the address held after an edge appears on the outputs during the cycle that follows, with no further register in the path.

A small state machine tracks the access phase. The states are `ST_IDLE` (deselected), `ST_WAKE` (the first cycle after a selecting load out of `ST_IDLE`), `ST_READ` and `ST_WRITE` (the cycle after a write edge). Every edge takes exactly one of these transitions. A load with the enables inactive goes to `ST_IDLE`. A load with the enables active goes to `ST_WRITE` if it writes. Otherwise it goes to `ST_WAKE` from `ST_IDLE`, or to `ST_READ` from any other state. With no load, `ST_IDLE` stays in `ST_IDLE`. Any other state moves to `ST_WRITE` on a write request and to `ST_READ` otherwise. The data outputs are enabled only in `ST_READ`, and only while the asynchronous output enable is low.

The storage depth is 2^`ADDR_W` words. Each word is `LANES` lanes of `LANE_W` bits, which by default gives 1024 words of 36 bits.

Top module: `sync_burst_sram`

## Requirements
- R1: While reset is applied, and after it is released with no load taken, `dq_oe` is 0.
- R2: A load taken by either strobe with the enables active (`ce1_n`=0, `ce2`=1, `ce3_n`=0) captures `addr`. Once out of `ST_WAKE`, `dq_o` shows the word at that address in the next cycle.
- R3: When `adsp_n` and `adsc_n` are low together with `ce1_n` low, the processor strobe is taken and the cycle is a read. No lane is written, even with `gw_n` low.
- R4: With `ce1_n` high, a low `adsp_n` is ignored. If `adsc_n` is high as well, the address is held and the device stays selected.
- R5: The chip enables have no effect on cycles without a load. A burst keeps running and reading while they are inactive.
- R6: With no load and `adv_n` low on a selected edge, the two low address bits step by +1 modulo 4 (for example 2, 3, 0, 1). The upper bits stay the same.
- R7: With no load and `adv_n` high, the address is held.
- R8: `gw_n` low on a writing edge writes all lanes, whatever `bwe_n` and `bw_n` are.
- R9: With `gw_n` high, lane i (bits i*LANE_W and up) is written only when `bwe_n` is low and `bw_n[i]` is low. With `bwe_n` high, nothing is written.
- R10: `dq_oe` is 0 in the cycle after a write edge, while deselected, and in the first cycle after a selecting load out of the deselected state. This holds even with `oe_n` low.
- R11: `oe_n` high forces `dq_oe` to 0 and `dq_o` to 0 with no clock edge needed. Bringing `oe_n` low in `ST_READ` enables the outputs at once.
- R12: A load with the enables inactive deselects the device and writes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | ADDR_W | Word address, captured on a load |
| adsp_n | input | 1 | Processor address strobe, active low, has priority |
| adsc_n | input | 1 | Controller address strobe, active low |
| ce1_n | input | 1 | Chip enable, active low; also gates `adsp_n` |
| ce2 | input | 1 | Chip enable, active high |
| ce3_n | input | 1 | Chip enable, active low |
| adv_n | input | 1 | Burst advance, active low |
| gw_n | input | 1 | Write all lanes, active low |
| bwe_n | input | 1 | Lane write enable, active low |
| bw_n | input | LANES | Per-lane write select, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| dq_i | input | LANES*LANE_W | Write data, sampled on the writing edge |
| dq_o | output | LANES*LANE_W | Read data, 0 when not driven |
| dq_oe | output | 1 | Data pin drive enable (0 means high impedance) |

## Verification
Several rules are checked by assertions on every cycle. After any lane write, a deselecting load or a wake-up load, the outputs must be off in the next cycle. The address must hold or step modulo 4 as `adv_n` directs. A processor-strobe load or a cycle with both write enables high must write no lane, and `oe_n` high must keep the drive off. Other behaviour is only visible through the bench's scenarios, because it depends on what was stored: the lane merge of a masked write, the global write overriding the masks, the old contents surviving a deselected write, reads continuing through a burst while the enables drop, and the wrap order as data read back.

// File: rtl/sbs_pkg.sv
`timescale 1ns/1ps
package sbs_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_WAKE  = 2'd1,
        ST_READ  = 2'd2,
        ST_WRITE = 2'd3
    } sbs_state_e;
endpackage

// File: rtl/sbs_lane_decode.sv
`timescale 1ns/1ps
module sbs_lane_decode #(
    parameter int LANES = 4
) (
    input  logic             allow,
    input  logic             gw_n,
    input  logic             bwe_n,
    input  logic [LANES-1:0] bw_n,
    output logic [LANES-1:0] lane_we
);
    for (genvar i = 0; i < LANES; i++) begin : g_lane
        assign lane_we[i] = allow & (~gw_n | (~bwe_n & ~bw_n[i]));
    end
endmodule

// File: rtl/sbs_addr_path.sv
`timescale 1ns/1ps
module sbs_addr_path #(
    parameter int ADDR_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              step,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] addr_q,
    output logic [ADDR_W-1:0] addr_nxt
);
    localparam int HI_W = ADDR_W - 2;

    logic [1:0] cnt_inc;
    assign cnt_inc = addr_q[1:0] + 2'd1;

    always_comb begin
        if (load) begin
            addr_nxt = addr_in;
        end else if (step) begin
            addr_nxt = {addr_q[ADDR_W-1:2], cnt_inc};
        end else begin
            addr_nxt = addr_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else begin
            addr_q <= addr_nxt;
        end
    end

    if (HI_W < 1) begin : g_bad_width
        initial $display("sbs_addr_path: ADDR_W must exceed 2");
    end
endmodule

// File: rtl/sbs_ctrl_fsm.sv
`timescale 1ns/1ps
module sbs_ctrl_fsm
    import sbs_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       adsp_n,
    input  logic       adsc_n,
    input  logic       ce1_n,
    input  logic       ce2,
    input  logic       ce3_n,
    input  logic       adv_n,
    input  logic       wr_req,
    input  logic       oe_n,
    output logic       load,
    output logic       step,
    output logic       wr_allow,
    output logic       dq_oe,
    output sbs_state_e state_q
);
    sbs_state_e state_d;
    logic       p_take;
    logic       c_take;
    logic       strobe;
    logic       ce_ok;

    assign p_take = ~adsp_n & ~ce1_n;
    assign c_take = ~adsc_n & ~p_take;
    assign strobe = p_take | ~adsc_n;
    assign ce_ok  = ~ce1_n & ce2 & ~ce3_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d  = state_q;
        load     = 1'b0;
        step     = 1'b0;
        wr_allow = 1'b0;
        if (strobe) begin
            if (ce_ok) begin
                load     = 1'b1;
                wr_allow = c_take & wr_req;
                if (wr_allow) begin
                    state_d = ST_WRITE;
                end else if (state_q == ST_IDLE) begin
                    state_d = ST_WAKE;
                end else begin
                    state_d = ST_READ;
                end
            end else begin
                state_d = ST_IDLE;
            end
        end else begin
            unique case (state_q)
                ST_IDLE: state_d = ST_IDLE;
                ST_WAKE, ST_READ, ST_WRITE: begin
                    step     = ~adv_n;
                    wr_allow = wr_req;
                    state_d  = wr_req ? ST_WRITE : ST_READ;
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    always_comb begin
        dq_oe = (state_q == ST_READ) & ~oe_n;
    end
endmodule

// File: rtl/sbs_array.sv
`timescale 1ns/1ps
module sbs_array #(
    parameter int ADDR_W = 10,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                     clk,
    input  logic [LANES-1:0]         lane_we,
    input  logic [ADDR_W-1:0]        waddr,
    input  logic [LANES*LANE_W-1:0]  wdata,
    input  logic [ADDR_W-1:0]        raddr,
    output logic [LANES*LANE_W-1:0]  rdata
);
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int DATA_W = LANES * LANE_W;

    logic [DATA_W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        for (int i = 0; i < LANES; i++) begin
            if (lane_we[i]) begin
                mem[waddr][i*LANE_W +: LANE_W] <= wdata[i*LANE_W +: LANE_W];
            end
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/sync_burst_sram.sv
`timescale 1ns/1ps
module sync_burst_sram
    import sbs_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int LANES  = 4,
    parameter int LANE_W = 9
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [ADDR_W-1:0]        addr,
    input  logic                     adsp_n,
    input  logic                     adsc_n,
    input  logic                     ce1_n,
    input  logic                     ce2,
    input  logic                     ce3_n,
    input  logic                     adv_n,
    input  logic                     gw_n,
    input  logic                     bwe_n,
    input  logic [LANES-1:0]         bw_n,
    input  logic                     oe_n,
    input  logic [LANES*LANE_W-1:0]  dq_i,
    output logic [LANES*LANE_W-1:0]  dq_o,
    output logic                     dq_oe
);
    localparam int DATA_W = LANES * LANE_W;

    sbs_state_e        state_q;
    logic              load;
    logic              step;
    logic              wr_allow;
    logic              wr_req;
    logic [LANES-1:0]  lane_we;
    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] addr_nxt;
    logic [DATA_W-1:0] rdata;

    assign wr_req = ~gw_n | (~bwe_n & ~(&bw_n));

    sbs_ctrl_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .adsp_n   (adsp_n),
        .adsc_n   (adsc_n),
        .ce1_n    (ce1_n),
        .ce2      (ce2),
        .ce3_n    (ce3_n),
        .adv_n    (adv_n),
        .wr_req   (wr_req),
        .oe_n     (oe_n),
        .load     (load),
        .step     (step),
        .wr_allow (wr_allow),
        .dq_oe    (dq_oe),
        .state_q  (state_q)
    );

    sbs_addr_path #(.ADDR_W(ADDR_W)) u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .step     (step),
        .addr_in  (addr),
        .addr_q   (addr_q),
        .addr_nxt (addr_nxt)
    );

    sbs_lane_decode #(.LANES(LANES)) u_lanes (
        .allow   (wr_allow),
        .gw_n    (gw_n),
        .bwe_n   (bwe_n),
        .bw_n    (bw_n),
        .lane_we (lane_we)
    );

    sbs_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
        .clk     (clk),
        .lane_we (lane_we),
        .waddr   (addr_nxt),
        .wdata   (dq_i),
        .raddr   (addr_q),
        .rdata   (rdata)
    );

    assign dq_o = dq_oe ? rdata : '0;
endmodule

// File: rtl/sbs_checker.sv
`timescale 1ns/1ps
module sbs_checker
    import sbs_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int LANES  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              adsp_n,
    input logic              adsc_n,
    input logic              ce1_n,
    input logic              ce2,
    input logic              ce3_n,
    input logic              adv_n,
    input logic              gw_n,
    input logic              bwe_n,
    input logic              oe_n,
    input sbs_state_e        state_q,
    input logic [ADDR_W-1:0] addr_q,
    input logic [LANES-1:0]  lane_we,
    input logic              dq_oe
);
    logic ld_req;
    logic en_ok;
    assign ld_req = (~adsp_n & ~ce1_n) | ~adsc_n;
    assign en_ok  = ~ce1_n & ce2 & ~ce3_n;

    a_r10_write_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (|lane_we) |=> !dq_oe);

    a_r10_wake_masked: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && ld_req && en_ok) |=> !dq_oe);

    a_r12_desel_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_req && !en_ok) |=> !dq_oe);

    a_r12_idle_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !ld_req) |-> (lane_we == '0));

    a_r7_hold_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_req && adv_n && state_q != ST_IDLE) |=> $stable(addr_q));

    a_r6_wrap_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_req && !adv_n && state_q != ST_IDLE) |=>
        ((addr_q[1:0] == 2'($past(addr_q[1:0]) + 2'd1)) &&
         (addr_q[ADDR_W-1:2] == $past(addr_q[ADDR_W-1:2]))));

    a_r3_ptake_reads: assert property (@(posedge clk) disable iff (!rst_n)
        (!adsp_n && !ce1_n) |-> (lane_we == '0));

    a_r9_no_enable: assert property (@(posedge clk) disable iff (!rst_n)
        (gw_n && bwe_n) |-> (lane_we == '0));

    a_r11_oe_off: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> !dq_oe);
endmodule

bind sync_burst_sram sbs_checker #(.ADDR_W(ADDR_W), .LANES(LANES)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .adsp_n  (adsp_n),
    .adsc_n  (adsc_n),
    .ce1_n   (ce1_n),
    .ce2     (ce2),
    .ce3_n   (ce3_n),
    .adv_n   (adv_n),
    .gw_n    (gw_n),
    .bwe_n   (bwe_n),
    .oe_n    (oe_n),
    .state_q (state_q),
    .addr_q  (addr_q),
    .lane_we (lane_we),
    .dq_oe   (dq_oe)
);

// File: tb/sync_burst_sram_bench.sv
`timescale 1ns/1ps
module sync_burst_sram_bench;
    localparam int AW = 10;
    localparam int NL = 4;
    localparam int LW = 9;
    localparam int DW = NL * LW;

    localparam logic [3:0] OP_LDC_RD   = 4'd0;
    localparam logic [3:0] OP_LDC_GW   = 4'd1;
    localparam logic [3:0] OP_LDC_BW   = 4'd2;
    localparam logic [3:0] OP_BWE_OFF  = 4'd3;
    localparam logic [3:0] OP_LDP      = 4'd4;
    localparam logic [3:0] OP_BOTH_GW  = 4'd5;
    localparam logic [3:0] OP_ADV      = 4'd6;
    localparam logic [3:0] OP_ADV_GW   = 4'd7;
    localparam logic [3:0] OP_HOLD     = 4'd8;
    localparam logic [3:0] OP_P_BLK    = 4'd9;
    localparam logic [3:0] OP_DESEL    = 4'd10;
    localparam logic [3:0] OP_ADV_CEOFF = 4'd11;

    typedef struct packed {
        logic [3:0]    op;
        logic [AW-1:0] addr;
        logic [NL-1:0] bw;
        logic          exp_oe;
    } vec_t;

    localparam int NV = 23;
    localparam vec_t VECS [NV] = '{
        '{OP_LDC_GW,    10'h020, 4'hF,    1'b0},
        '{OP_LDC_GW,    10'h010, 4'hF,    1'b0},
        '{OP_ADV_GW,    10'h000, 4'hF,    1'b0},
        '{OP_ADV_GW,    10'h000, 4'hF,    1'b0},
        '{OP_ADV_GW,    10'h000, 4'hF,    1'b0},
        '{OP_LDC_RD,    10'h012, 4'hF,    1'b1},
        '{OP_ADV,       10'h000, 4'hF,    1'b1},
        '{OP_ADV,       10'h000, 4'hF,    1'b1},
        '{OP_ADV,       10'h000, 4'hF,    1'b1},
        '{OP_HOLD,      10'h000, 4'hF,    1'b1},
        '{OP_LDC_BW,    10'h011, 4'b1010, 1'b0},
        '{OP_HOLD,      10'h000, 4'hF,    1'b1},
        '{OP_BWE_OFF,   10'h012, 4'h0,    1'b1},
        '{OP_BOTH_GW,   10'h013, 4'hF,    1'b1},
        '{OP_P_BLK,     10'h000, 4'hF,    1'b1},
        '{OP_DESEL,     10'h020, 4'hF,    1'b0},
        '{OP_ADV,       10'h000, 4'hF,    1'b0},
        '{OP_LDC_RD,    10'h010, 4'hF,    1'b0},
        '{OP_ADV_CEOFF, 10'h000, 4'hF,    1'b1},
        '{OP_LDP,       10'h013, 4'hF,    1'b1},
        '{OP_ADV,       10'h000, 4'hF,    1'b1},
        '{OP_LDC_RD,    10'h020, 4'hF,    1'b1},
        '{OP_HOLD,      10'h000, 4'hF,    1'b1}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = '0;
    logic          adsp_n = 1'b1, adsc_n = 1'b1, ce1_n = 1'b0, ce2 = 1'b1, ce3_n = 1'b0;
    logic          adv_n = 1'b1, gw_n = 1'b1, bwe_n = 1'b1, oe_n = 1'b0;
    logic [NL-1:0] bw_n = '1;
    logic [DW-1:0] dq_i = '0;
    logic [DW-1:0] dq_o;
    logic          dq_oe;

    int checks = 0;
    int errors = 0;

    logic [DW-1:0] m_mem [1 << AW];
    logic [AW-1:0] m_addr = '0;
    logic          m_idle = 1'b1;

    always #2 clk = ~clk;

    sync_burst_sram #(.ADDR_W(AW), .LANES(NL), .LANE_W(LW)) u_sync_burst_sram (
        .clk(clk), .rst_n(rst_n), .addr(addr), .adsp_n(adsp_n), .adsc_n(adsc_n),
        .ce1_n(ce1_n), .ce2(ce2), .ce3_n(ce3_n), .adv_n(adv_n), .gw_n(gw_n),
        .bwe_n(bwe_n), .bw_n(bw_n), .oe_n(oe_n), .dq_i(dq_i), .dq_o(dq_o), .dq_oe(dq_oe)
    );

    function automatic logic [DW-1:0] dpat(int i);
        return DW'({4'(i), 32'h9E37_79B9 * 32'(i + 1)});
    endfunction

    function automatic string req_of(logic [3:0] op);
        case (op)
            OP_LDC_RD:    return "R2 R8";
            OP_LDC_GW:    return "R10 R8";
            OP_ADV_GW:    return "R10 R8";
            OP_LDC_BW:    return "R10 R9";
            OP_BWE_OFF:   return "R9";
            OP_LDP:       return "R2";
            OP_BOTH_GW:   return "R3";
            OP_ADV:       return "R6 R10";
            OP_HOLD:      return "R7 R9 R12";
            OP_P_BLK:     return "R4";
            OP_DESEL:     return "R12";
            OP_ADV_CEOFF: return "R5";
            default:      return "R?";
        endcase
    endfunction

    task automatic chk(string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic set_idle();
        adsp_n = 1'b1; adsc_n = 1'b1; ce1_n = 1'b0; ce2 = 1'b1; ce3_n = 1'b0;
        adv_n = 1'b1; gw_n = 1'b1; bwe_n = 1'b1; bw_n = '1; oe_n = 1'b0;
    endtask

    // Reference model of one edge, written from the requirements
    task automatic model_edge();
        logic p_take, strobe, en_ok, wr;
        logic [AW-1:0] waddr;
        p_take = !adsp_n && !ce1_n;
        strobe = p_take || !adsc_n;
        en_ok  = !ce1_n && ce2 && !ce3_n;
        wr     = !gw_n || (!bwe_n && !(&bw_n));
        waddr  = m_addr;
        if (strobe) begin
            if (en_ok) begin
                m_addr = addr;
                m_idle = 1'b0;
                if (p_take) wr = 1'b0;
            end else begin
                m_idle = 1'b1;
                wr = 1'b0;
            end
        end else if (m_idle) begin
            wr = 1'b0;
        end else if (!adv_n) begin
            m_addr[1:0] = m_addr[1:0] + 2'd1;
        end
        waddr = m_addr;
        if (wr) begin
            for (int l = 0; l < NL; l++) begin
                if (!gw_n || !bw_n[l]) m_mem[waddr][l*LW +: LW] = dq_i[l*LW +: LW];
            end
        end
    endtask

    initial begin
        #800000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual running expected done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        set_idle();
        repeat (3) @(posedge clk);
        #1;
        chk("R1 during reset", DW'(dq_oe), '0);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        chk("R1 after reset", DW'(dq_oe), '0);

        for (int v = 0; v < NV; v++) begin
            set_idle();
            addr = VECS[v].addr;
            dq_i = dpat(v);
            case (VECS[v].op)
                OP_LDC_RD:    adsc_n = 1'b0;
                OP_LDC_GW:    begin adsc_n = 1'b0; gw_n = 1'b0; end
                OP_LDC_BW:    begin adsc_n = 1'b0; bwe_n = 1'b0; bw_n = VECS[v].bw; end
                OP_BWE_OFF:   begin adsc_n = 1'b0; bw_n = VECS[v].bw; end
                OP_LDP:       adsp_n = 1'b0;
                OP_BOTH_GW:   begin adsp_n = 1'b0; adsc_n = 1'b0; gw_n = 1'b0; end
                OP_ADV:       adv_n = 1'b0;
                OP_ADV_GW:    begin adv_n = 1'b0; gw_n = 1'b0; bw_n = '1; end
                OP_HOLD:      ;
                OP_P_BLK:     begin adsp_n = 1'b0; ce1_n = 1'b1; end
                OP_DESEL:     begin adsc_n = 1'b0; ce2 = 1'b0; gw_n = 1'b0; end
                OP_ADV_CEOFF: begin adv_n = 1'b0; ce1_n = 1'b1; ce2 = 1'b0; end
                default:      ;
            endcase
            @(posedge clk);
            model_edge();
            #1;
            chk($sformatf("%s vec %0d dq_oe", req_of(VECS[v].op), v),
                DW'(dq_oe), DW'(VECS[v].exp_oe));
            if (VECS[v].exp_oe) begin
                chk($sformatf("%s vec %0d dq_o", req_of(VECS[v].op), v), dq_o, m_mem[m_addr]);
            end else begin
                chk($sformatf("%s vec %0d dq_o quiet", req_of(VECS[v].op), v), dq_o, '0);
            end
        end

        // R11: output enable acts without a clock edge
        set_idle();
        @(negedge clk);
        oe_n = 1'b1;
        #0.5;
        chk("R11 oe_n high dq_oe", DW'(dq_oe), '0);
        chk("R11 oe_n high dq_o", dq_o, '0);
        oe_n = 1'b0;
        #0.5;
        chk("R11 oe_n low dq_oe", DW'(dq_oe), DW'(1'b1));
        chk("R11 oe_n low dq_o", dq_o, m_mem[10'h020]);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule